// File: doc/BRIEF.md
# Register Block Load/Store Sequencer

This block runs the bulk register-to-memory and memory-to-register moves of a small 8-bit virtual machine. When the core issues a start pulse with a direction, a highest register number x and the current index pointer, the sequencer moves registers 0 through x. It makes one byte transfer per clock. Each transfer either copies register k to memory address pointer + k, or fills register k from that address. The memory and the register file sit outside the block. Both are reached through simple ports with a combinational read path.

When the last byte has moved, the block pulses done and presents the new pointer value. Two configuration inputs choose how the pointer advances. With neither set, it advances past the whole block. The first option advances it to the last byte touched. The second option leaves it where it was. Setting both options at once is a configuration clash, which the block flags. A third configuration input widens the address space from 4 KiB to 64 KiB. All configuration inputs are sampled when a job starts.

Top module: `regxfer_seq`

## Requirements
- R1: A start pulse seen while idle is accepted on that clock edge. busy is high from the next cycle for exactly x+1 cycles, with one transfer in each of those cycles.
- R2: Store direction (dir_load=0): in transfer k, rf_idx=k, mem_we=1, mem_re=0, rf_we=0 and mem_wdata equals rf_rdata.
- R3: Load direction (dir_load=1): in transfer k, mem_re=1, rf_we=1, mem_we=0, rf_idx=k and rf_wdata equals mem_rdata. Afterwards, registers 0..x hold the bytes read.
- R4: Transfers run in ascending order. The first transfer uses register 0 at address pointer+0, and each later transfer adds one to both the register number and the address.
- R5: done is a single-cycle pulse in the cycle right after the last transfer. busy is low in that cycle.
- R6: With inc_by_x=0 and keep_idx=0, idx_out equals pointer + x + 1 while done is high.
- R7: With inc_by_x=1 and keep_idx=0, idx_out equals pointer + x.
- R8: With keep_idx=1 and inc_by_x=0, idx_out equals the starting pointer.
- R9: cfg_err is high exactly when inc_by_x and keep_idx are both high. A job started in that state ends with idx_out equal to pointer + x + 1.
- R10: With wide_addr=0, mem_addr and idx_out are reduced modulo 4096 (bits 15:12 are zero). With wide_addr=1, they wrap modulo 65536.
- R11: A start pulse while busy is ignored. The running job keeps its transfer count, addresses, pointer result and configuration, even if x, pointer, direction or mode change meanwhile.
- R12: After reset, busy, done, mem_we, mem_re and rf_we are low and idx_out is zero. No strobe is active while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job (accepted only while idle) |
| dir_load | input | 1 | 0 = registers to memory, 1 = memory to registers |
| x | input | 4 | Highest register number to transfer |
| idx_in | input | 16 | Pointer value at start |
| inc_by_x | input | 1 | Pointer ends at start + x |
| keep_idx | input | 1 | Pointer left unchanged |
| wide_addr | input | 1 | 64 KiB address space instead of 4 KiB |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Byte written to memory |
| mem_rdata | input | 8 | Byte read from memory (same cycle) |
| rf_idx | output | 4 | Register number |
| rf_we | output | 1 | Register write strobe |
| rf_wdata | output | 8 | Byte written to the register |
| rf_rdata | input | 8 | Register content (same cycle) |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| idx_out | output | 16 | Updated pointer, valid with done |
| cfg_err | output | 1 | Both pointer options set |

## Verification
The bench runs stores and loads with x of 0, a mid value and 15. These runs separate the per-transfer strobe and data routing from the transfer count, and expose off-by-one errors in the last register. Each pointer option, and the clash, is run on its own with the same x, so the three end-pointer formulas and the fallback rule give distinct values. A base just below 4 KiB is run in both address widths, and a base just below 64 KiB in the wide width, which separates wrapping from carrying into bit 12. A second start with different x, base and options arrives mid-job, and the transfer count, addresses and final pointer show that it is ignored.

// File: rtl/regxfer_pkg.sv
package regxfer_pkg;

    typedef enum logic {
        XFER_STORE = 1'b0,
        XFER_LOAD  = 1'b1
    } xfer_dir_e;

    // Encoding is {keep_idx, inc_by_x}
    typedef enum logic [1:0] {
        IDX_FULL  = 2'b00,
        IDX_BY_X  = 2'b01,
        IDX_HOLD  = 2'b10,
        IDX_CLASH = 2'b11
    } idx_mode_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    function automatic idx_mode_e pack_mode(input logic by_x, input logic hold);
        return idx_mode_e'({hold, by_x});
    endfunction

    function automatic logic mode_is_clash(input idx_mode_e m);
        return m == IDX_CLASH;
    endfunction

endpackage

// File: rtl/regxfer_agen.sv
module regxfer_agen #(
    parameter int AW        = 16,
    parameter int NARROW_AW = 12
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] offset,
    input  logic          wide,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] NARROW_MASK = AW'((1 << NARROW_AW) - 1);
    localparam logic [AW-1:0] WIDE_MASK   = '1;

    logic [AW-1:0] sum;

    always_comb begin
        sum  = base + offset;
        addr = sum & (wide ? WIDE_MASK : NARROW_MASK);
    end
endmodule

// File: rtl/regxfer_idxcalc.sv
module regxfer_idxcalc
    import regxfer_pkg::*;
#(
    parameter int AW        = 16,
    parameter int NARROW_AW = 12,
    parameter int XW        = 4
) (
    input  logic [AW-1:0] base,
    input  logic [XW-1:0] last,
    input  idx_mode_e     mode,
    input  logic          wide,
    output logic [AW-1:0] idx_next
);
    logic [AW-1:0] span;
    logic [AW-1:0] delta;

    always_comb begin
        span = {{(AW-XW){1'b0}}, last};
        unique case (mode)
            IDX_HOLD: delta = '0;
            IDX_BY_X: delta = span;
            default:  delta = span + AW'(1); // full step, also on a clash
        endcase
    end

    regxfer_agen #(.AW(AW), .NARROW_AW(NARROW_AW)) u_wrap (
        .base   (base),
        .offset (delta),
        .wide   (wide),
        .addr   (idx_next)
    );
endmodule

// File: rtl/regxfer_ctrl.sv
module regxfer_ctrl
    import regxfer_pkg::*;
#(
    parameter int XW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [XW-1:0] x,
    output logic          accept,
    output logic          busy,
    output logic          at_last,
    output logic [XW-1:0] cnt,
    output logic          done
);
    seq_state_e    state;
    logic [XW-1:0] last_q;

    assign busy    = (state == SEQ_RUN);
    assign accept  = start && !busy;
    assign at_last = busy && (cnt == last_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            cnt    <= '0;
            last_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state  <= SEQ_RUN;
                        cnt    <= '0;
                        last_q <= x;
                    end
                end
                SEQ_RUN: begin
                    if (cnt == last_q) begin
                        state <= SEQ_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt + XW'(1);
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/regxfer_seq.sv
module regxfer_seq
    import regxfer_pkg::*;
#(
    parameter int AW        = 16,
    parameter int NARROW_AW = 12,
    parameter int DW        = 8,
    parameter int NREG      = 16,
    localparam int XW       = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          dir_load,
    input  logic [XW-1:0] x,
    input  logic [AW-1:0] idx_in,
    input  logic          inc_by_x,
    input  logic          keep_idx,
    input  logic          wide_addr,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic          mem_re,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [XW-1:0] rf_idx,
    output logic          rf_we,
    output logic [DW-1:0] rf_wdata,
    input  logic [DW-1:0] rf_rdata,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] idx_out,
    output logic          cfg_err
);
    typedef struct packed {
        xfer_dir_e     dir;
        idx_mode_e     mode;
        logic          wide;
        logic [AW-1:0] base;
        logic [XW-1:0] last;
    } job_t;

    job_t          job;
    logic          accept;
    logic          at_last;
    logic [XW-1:0] cnt;
    logic [AW-1:0] idx_next;
    logic          is_load;

    assign cfg_err = mode_is_clash(pack_mode(inc_by_x, keep_idx));

    regxfer_ctrl #(.XW(XW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .x       (x),
        .accept  (accept),
        .busy    (busy),
        .at_last (at_last),
        .cnt     (cnt),
        .done    (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            job <= '{dir: XFER_STORE, mode: IDX_FULL, wide: 1'b0, base: '0, last: '0};
        end else if (accept) begin
            job.dir  <= xfer_dir_e'(dir_load);
            job.mode <= pack_mode(inc_by_x, keep_idx);
            job.wide <= wide_addr;
            job.base <= idx_in;
            job.last <= x;
        end
    end

    regxfer_agen #(.AW(AW), .NARROW_AW(NARROW_AW)) u_agen (
        .base   (job.base),
        .offset ({{(AW-XW){1'b0}}, cnt}),
        .wide   (job.wide),
        .addr   (mem_addr)
    );

    regxfer_idxcalc #(.AW(AW), .NARROW_AW(NARROW_AW), .XW(XW)) u_idx (
        .base     (job.base),
        .last     (job.last),
        .mode     (job.mode),
        .wide     (job.wide),
        .idx_next (idx_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_out <= '0;
        end else if (at_last) begin
            idx_out <= idx_next;
        end
    end

    assign is_load   = (job.dir == XFER_LOAD);
    assign mem_we    = busy && !is_load;
    assign mem_re    = busy && is_load;
    assign rf_we     = busy && is_load;
    assign rf_idx    = cnt;
    assign mem_wdata = rf_rdata;
    assign rf_wdata  = mem_rdata;
endmodule

// File: rtl/regxfer_chk.sv
module regxfer_chk #(
    parameter int AW        = 16,
    parameter int NARROW_AW = 12,
    parameter int XW        = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          wide_addr,
    input logic          busy,
    input logic          done,
    input logic          mem_we,
    input logic          mem_re,
    input logic          rf_we,
    input logic [XW-1:0] rf_idx,
    input logic [AW-1:0] mem_addr
);
    assert_start_busy_R1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_load_pair_R3: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (mem_re && !mem_we));

    assert_first_reg_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !$past(busy)) |-> (rf_idx == '0));

    assert_ascend_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (rf_idx == $past(rf_idx) + XW'(1)));

    assert_done_idle_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_end_done_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_narrow_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !$past(busy) && !$past(wide_addr)) |-> (mem_addr[AW-1:NARROW_AW] == '0));

    assert_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(mem_we || mem_re || rf_we));

    assert_strobe_one_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_we, mem_re}));
endmodule

bind regxfer_seq regxfer_chk #(.AW(AW), .NARROW_AW(NARROW_AW), .XW(XW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .wide_addr (wide_addr),
    .busy      (busy),
    .done      (done),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .rf_we     (rf_we),
    .rf_idx    (rf_idx),
    .mem_addr  (mem_addr)
);

// File: tb/test_regxfer_seq.sv
`timescale 1ns/1ps
module test_regxfer_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        dir_load = 1'b0;
    logic [3:0]  x = '0;
    logic [15:0] idx_in = '0;
    logic        inc_by_x = 1'b0;
    logic        keep_idx = 1'b0;
    logic        wide_addr = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_we, mem_re, rf_we, busy, done, cfg_err;
    logic [7:0]  mem_wdata, mem_rdata, rf_wdata, rf_rdata;
    logic [3:0]  rf_idx;
    logic [15:0] idx_out;

    logic [7:0]  regs [16];
    int          n_checks = 0;
    int          n_errors = 0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mem_pat(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    assign mem_rdata = mem_pat(mem_addr);
    assign rf_rdata  = regs[rf_idx];

    always @(posedge clk) if (rf_we) regs[rf_idx] <= rf_wdata;

    regxfer_seq i_regxfer_seq (
        .clk(clk), .rst(rst), .start(start), .dir_load(dir_load), .x(x),
        .idx_in(idx_in), .inc_by_x(inc_by_x), .keep_idx(keep_idx), .wide_addr(wide_addr),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .rf_idx(rf_idx), .rf_we(rf_we), .rf_wdata(rf_wdata),
        .rf_rdata(rf_rdata), .busy(busy), .done(done), .idx_out(idx_out), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_addr(input logic [15:0] b, input int k, input bit w);
        logic [15:0] s;
        s = b + 16'(k);
        return w ? s : (s & 16'h0FFF);
    endfunction

    function automatic logic [15:0] exp_idx(input logic [15:0] b, input int xv,
                                            input bit byx, input bit hold, input bit w);
        int d;
        if (hold && !byx)      d = 0;
        else if (byx && !hold) d = xv;
        else                   d = xv + 1;
        return exp_addr(b, d, w);
    endfunction

    task automatic preload();
        for (int i = 0; i < 16; i++) regs[i] = 8'hA3 + 8'(i * 13);
    endtask

    // One job; poke=1 issues a conflicting start during the job (R11)
    task automatic run_job(input bit ld, input int xv, input logic [15:0] b,
                           input bit byx, input bit hold, input bit w,
                           input string req, input bit poke);
        logic [7:0] snap [16];
        int moves = 0;
        for (int i = 0; i < 16; i++) snap[i] = regs[i];
        @(negedge clk);
        dir_load = ld; x = 4'(xv); idx_in = b; inc_by_x = byx; keep_idx = hold; wide_addr = w;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= xv; k++) begin
            if (poke && k == 1) begin
                start = 1'b1; x = 4'd9; idx_in = 16'h0ABC; dir_load = ~ld;
                keep_idx = ~hold; wide_addr = ~w;
            end else if (poke && k == 2) begin
                start = 1'b0;
            end
            if (busy) moves++;
            chk(busy, "R1", "busy during transfer", busy, 1);
            chk(rf_idx == 4'(k), "R4", "register order", rf_idx, k);
            chk(mem_addr == exp_addr(b, k, w), w ? "R4" : "R10", "address", mem_addr, exp_addr(b, k, w));
            if (ld) begin
                chk(mem_re && rf_we && !mem_we, "R3", "load strobes", {mem_we, mem_re, rf_we}, 3'b011);
                chk(rf_wdata == mem_pat(exp_addr(b, k, w)), "R3", "load data", rf_wdata, mem_pat(exp_addr(b, k, w)));
            end else begin
                chk(mem_we && !mem_re && !rf_we, "R2", "store strobes", {mem_we, mem_re, rf_we}, 3'b100);
                chk(mem_wdata == snap[k], "R2", "store data", mem_wdata, snap[k]);
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(moves == xv + 1, poke ? "R11" : "R1", "transfer count", moves, xv + 1);
        chk(done && !busy, "R5", "done pulse", {done, busy}, 2'b10);
        chk(idx_out == exp_idx(b, xv, byx, hold, w), req, "final pointer",
            idx_out, exp_idx(b, xv, byx, hold, w));
        @(negedge clk);
        chk(!done && !busy, poke ? "R11" : "R5", "idle after done", {done, busy}, 2'b00);
        if (ld) begin
            for (int k = 0; k <= xv; k++)
                chk(regs[k] == mem_pat(exp_addr(b, k, w)), "R3", "register loaded", regs[k], mem_pat(exp_addr(b, k, w)));
            if (xv < 15)
                chk(regs[xv+1] == snap[xv+1], "R3", "register above x untouched", regs[xv+1], snap[xv+1]);
        end
        inc_by_x = 1'b0; keep_idx = 1'b0;
    endtask

    task automatic t_reset();
        chk(!busy && !done, "R12", "reset busy/done", {busy, done}, 0);
        chk(!mem_we && !mem_re && !rf_we, "R12", "reset strobes", {mem_we, mem_re, rf_we}, 0);
        chk(idx_out == 16'h0, "R12", "reset pointer", idx_out, 0);
    endtask

    task automatic t_default();
        run_job(1'b0, 5, 16'h0200, 1'b0, 1'b0, 1'b0, "R6", 1'b0);
        run_job(1'b1, 15, 16'h0300, 1'b0, 1'b0, 1'b0, "R6", 1'b0);
        run_job(1'b0, 0, 16'h0400, 1'b0, 1'b0, 1'b0, "R6", 1'b0);
    endtask

    task automatic t_by_x();
        run_job(1'b1, 6, 16'h0500, 1'b1, 1'b0, 1'b0, "R7", 1'b0);
    endtask

    task automatic t_hold();
        run_job(1'b0, 6, 16'h0600, 1'b0, 1'b1, 1'b0, "R8", 1'b0);
    endtask

    task automatic t_clash();
        @(negedge clk);
        inc_by_x = 1'b1; keep_idx = 1'b0; #0.1;
        chk(!cfg_err, "R9", "no clash with one option", cfg_err, 0);
        inc_by_x = 1'b1; keep_idx = 1'b1; #0.1;
        chk(cfg_err, "R9", "clash flagged", cfg_err, 1);
        run_job(1'b0, 6, 16'h0700, 1'b1, 1'b1, 1'b0, "R9", 1'b0);
    endtask

    task automatic t_wrap();
        run_job(1'b0, 4, 16'h0FFE, 1'b0, 1'b0, 1'b0, "R10", 1'b0);
        run_job(1'b1, 2, 16'h0FFE, 1'b0, 1'b0, 1'b1, "R10", 1'b0);
        run_job(1'b0, 3, 16'hFFFE, 1'b0, 1'b0, 1'b1, "R10", 1'b0);
    endtask

    task automatic t_ignore_start();
        run_job(1'b0, 3, 16'h0123, 1'b0, 1'b0, 1'b0, "R11", 1'b1);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        preload();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_default();
        preload();
        t_by_x();
        t_hold();
        t_clash();
        t_wrap();
        preload();
        t_ignore_start();
        repeat (2) @(negedge clk);
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
    end
endmodule